// File: doc/BRIEF.md
# UART Interrupt Priority and Identification

This block merges the interrupt causes of a serial port into one interrupt line and builds the byte that software reads to learn the cause. Four kinds of cause come in as inputs from the detection logic around it: a receiver error condition, received data (with a separate character-timeout condition), an event that marks the transmit holding register as empty, and a set of modem-line change flags. An enable byte gates each kind. When several are pending at once, only the most urgent one is reported.

The identification byte holds four fields. Bit 0 is a pending flag that is active low. Bits 3:1 hold a code for the cause being reported. Bits 5:4 always read zero. Bits 7:6 show whether the FIFOs are on. Most conditions are levels, and the logic that raised them also clears them. The transmit-empty cause is the exception: it arrives as a one-cycle event and is held here until the identification byte is read while that cause is the one reported, or until the holding register is written.

Top module: `uart_irq_ident`

## Requirements
- R1: Enable bit 0 gates both data-available and character-timeout. Bit 1 gates transmit-holding-empty, bit 2 gates the receiver error condition, and bit 3 gates modem change. Enable bits 7:4 have no effect. A transmit-empty cause held while bit 1 is clear is reported once bit 1 is set.
- R2: Bit 0 of the identification byte reads 0 when any enabled cause is pending and 1 otherwise. The `irq` output is the inverse of this bit.
- R3: An enabled receiver error condition has the highest priority and reads bits 3:1 = 011, giving a low nibble of 0x6.
- R4: Enabled data-available, with no receiver error, reads bits 3:1 = 010, giving a low nibble of 0x4.
- R5: An enabled character-timeout is at the same priority level as data-available and reads bits 3:1 = 110, giving a low nibble of 0xC. It takes that code even when data-available is also pending.
- R6: A held transmit-empty cause, below the data level, reads bits 3:1 = 001, giving a low nibble of 0x2.
- R7: Enabled modem change, with any of its flags set, has the lowest priority and reads bits 3:1 = 000, giving a low nibble of 0x0.
- R8: A transmit-empty event is held from the next clock edge. An identification read clears it only when transmit-empty is the cause reported in that cycle. A read while another cause is reported leaves it held.
- R9: A holding-register write clears the held transmit-empty cause, and wins over a transmit-empty event in the same cycle. A transmit-empty event wins over an identification read in the same cycle.
- R10: Bits 7:6 read 11 when the FIFOs are on and 00 when they are off. Bits 5:4 always read 0.
- R11: After reset, no transmit-empty cause is held. A transmit-empty event seen during reset is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_en | input | 8 | Interrupt enable byte |
| lsr_err | input | 1 | Receiver error condition pending (level) |
| rx_avail | input | 1 | Received data available (level) |
| rx_timeout | input | 1 | Character timeout pending (level) |
| thr_empty_evt | input | 1 | One-cycle event: transmit holding register became empty |
| modem_delta | input | MDM_W | Modem-line change flags (level) |
| fifo_on | input | 1 | FIFOs enabled |
| id_rd | input | 1 | Identification byte read strobe |
| thr_wr | input | 1 | Holding-register write strobe |
| irq | output | 1 | Interrupt request, active high |
| id_byte | output | 8 | Identification byte |

## Verification
Three strobes can land in the same cycle as the held transmit-empty cause changes. These are the transmit-empty event, the holding-register write and the identification read. The bench pairs them on purpose: it drives a write together with an event, then an event together with a read while transmit-empty is the reported cause. The result is judged one cycle later at the identification byte, which must show the cause gone in the first case and still reported in the second. A read taken while a higher cause hides transmit-empty is also checked; transmit-empty must appear intact once that higher cause drops.

// File: rtl/uart_irq_ident.sv
module uart_irq_ident #(
  parameter int MDM_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [7:0]       irq_en,
  input  logic             lsr_err,
  input  logic             rx_avail,
  input  logic             rx_timeout,
  input  logic             thr_empty_evt,
  input  logic [MDM_W-1:0] modem_delta,
  input  logic             fifo_on,
  input  logic             id_rd,
  input  logic             thr_wr,
  output logic             irq,
  output logic [7:0]       id_byte
);

  localparam logic [2:0] C_LSR = 3'b011;
  localparam logic [2:0] C_RDA = 3'b010;
  localparam logic [2:0] C_TMO = 3'b110;
  localparam logic [2:0] C_THR = 3'b001;
  localparam logic [2:0] C_MSR = 3'b000;

  logic       thre_pend;
  logic       none;
  logic [2:0] code;

  wire lsr_hit = irq_en[2] & lsr_err;
  wire tmo_hit = irq_en[0] & rx_timeout;
  wire rda_hit = irq_en[0] & rx_avail;
  wire thr_hit = irq_en[1] & thre_pend;
  wire msr_hit = irq_en[3] & (|modem_delta);

  always_comb begin
    none = 1'b0;
    code = C_MSR;
    if (lsr_hit)      code = C_LSR;
    else if (tmo_hit) code = C_TMO;
    else if (rda_hit) code = C_RDA;
    else if (thr_hit) code = C_THR;
    else if (msr_hit) code = C_MSR;
    else              none = 1'b1;
  end

  assign id_byte = {{2{fifo_on}}, 2'b00, code, none};
  assign irq     = ~none;

  wire thr_ack = id_rd & ~none & (code == C_THR);

  always_ff @(posedge clk) begin
    if (!rst_n)             thre_pend <= 1'b0;
    else if (thr_wr)        thre_pend <= 1'b0;
    else if (thr_empty_evt) thre_pend <= 1'b1;
    else if (thr_ack)       thre_pend <= 1'b0;
  end

  p_fifo_bits_r10: assert property (@(posedge clk) disable iff (!rst_n)
    id_byte[7:6] == {fifo_on, fifo_on} && id_byte[5:4] == 2'b00);

  p_lsr_first_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (lsr_err && irq_en[2]) |-> (id_byte[3:0] == 4'h6 && irq));

  p_timeout_code_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_timeout && irq_en[0] && !(lsr_err && irq_en[2])) |-> id_byte[3:0] == 4'hC);

  p_write_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
    thr_wr |=> id_byte[3:0] != 4'h2);

  p_read_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (id_rd && id_byte[3:0] == 4'h2 && !thr_empty_evt) |=> id_byte[3:0] != 4'h2);

  p_event_holds_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (thr_empty_evt && !thr_wr && irq_en[1] && !lsr_err && !rx_avail && !rx_timeout)
    |=> (irq_en[1] && !lsr_err && !rx_avail && !rx_timeout) |-> id_byte[3:0] == 4'h2);

  p_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_en[3:0] == 4'h0) |-> (!irq && id_byte[0]));

endmodule

// File: tb/tb_uart_irq_ident.sv
module tb_uart_irq_ident;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] irq_en = '0;
  logic       lsr_err = 1'b0, rx_avail = 1'b0, rx_timeout = 1'b0;
  logic       thr_empty_evt = 1'b0, fifo_on = 1'b0, id_rd = 1'b0, thr_wr = 1'b0;
  logic [3:0] modem_delta = '0;
  logic       irq;
  logic [7:0] id_byte;

  uart_irq_ident #(.MDM_W(4)) dut (
    .clk(clk), .rst_n(rst_n), .irq_en(irq_en), .lsr_err(lsr_err),
    .rx_avail(rx_avail), .rx_timeout(rx_timeout), .thr_empty_evt(thr_empty_evt),
    .modem_delta(modem_delta), .fifo_on(fifo_on), .id_rd(id_rd), .thr_wr(thr_wr),
    .irq(irq), .id_byte(id_byte)
  );

  always #4 clk = ~clk;

  typedef struct { logic [8:0] exp; string tag; } item_t;
  item_t q[$];
  int n_run = 0, n_fail = 0;
  bit thre_m = 1'b0;
  bit done = 1'b0;

  function automatic logic [7:0] model(logic [7:0] en, logic l, logic a, logic t,
                                       logic [3:0] m, logic f, bit th);
    logic [3:0] lo;
    if (en[2] && l)             lo = 4'h6;
    else if (en[0] && t)        lo = 4'hC;
    else if (en[0] && a)        lo = 4'h4;
    else if (en[1] && th)       lo = 4'h2;
    else if (en[3] && (|m))     lo = 4'h0;
    else                        lo = 4'h1;
    return {f, f, 2'b00, lo};
  endfunction

  task automatic step(input logic [7:0] en, input logic l, input logic a, input logic t,
                      input logic tev, input logic [3:0] m, input logic f,
                      input logic rd, input logic wr, input logic rs, input string tag);
    item_t it;
    logic [7:0] e;
    @(negedge clk);
    rst_n = rs; irq_en = en; lsr_err = l; rx_avail = a; rx_timeout = t;
    thr_empty_evt = tev; modem_delta = m; fifo_on = f; id_rd = rd; thr_wr = wr;
    e = model(en, l, a, t, m, f, thre_m);
    it.exp = {~e[0], e};
    it.tag = tag;
    q.push_back(it);
    if (!rs)       thre_m = 1'b0;
    else if (wr)   thre_m = 1'b0;
    else if (tev)  thre_m = 1'b1;
    else if (rd && e[3:0] == 4'h2) thre_m = 1'b0;
  endtask

  initial begin
    forever begin
      @(negedge clk);
      #3;
      if (q.size() > 0) begin
        item_t it;
        it = q.pop_front();
        n_run++;
        if ({irq, id_byte} !== it.exp) begin
          n_fail++;
          $display("FAIL %s: got irq=%b id=%h, expected irq=%b id=%h",
                   it.tag, irq, id_byte, it.exp[8], it.exp[7:0]);
        end
      end
    end
  end

  initial begin
    step(8'h02, 0,0,0, 1, 4'h0, 0, 0,0, 0, "R11 event in reset");
    step(8'h02, 0,0,0, 0, 4'h0, 0, 0,0, 1, "R11 reset state");
    step(8'h02, 0,0,0, 0, 4'h0, 0, 0,0, 1, "R11 event discarded");
    step(8'h00, 0,0,0, 0, 4'h0, 1, 0,0, 1, "R10 fifo on idle");
    step(8'h01, 0,1,0, 0, 4'h0, 0, 0,0, 1, "R4 data available");
    step(8'h01, 0,1,0, 0, 4'h0, 1, 0,0, 1, "R2 irq with data");
    step(8'hF0, 1,1,1, 0, 4'hF, 1, 0,0, 1, "R1 upper enables ignored");
    step(8'h05, 1,1,0, 0, 4'h0, 0, 0,0, 1, "R3 error over data");
    step(8'h01, 0,0,1, 0, 4'h0, 0, 0,0, 1, "R5 timeout code");
    step(8'h01, 0,1,1, 0, 4'h0, 0, 0,0, 1, "R5 timeout with data");
    step(8'h05, 1,0,1, 0, 4'h0, 0, 0,0, 1, "R3 error over timeout");
    step(8'h04, 0,1,1, 0, 4'h0, 0, 0,0, 1, "R1 bit2 does not gate data");
    step(8'h08, 0,0,0, 0, 4'h2, 0, 0,0, 1, "R7 modem code");
    step(8'h0A, 0,0,0, 1, 4'h2, 0, 0,0, 1, "R7 modem before event");
    step(8'h0A, 0,0,0, 0, 4'h2, 0, 0,0, 1, "R6 transmit over modem");
    step(8'h0B, 0,1,0, 0, 4'h2, 0, 1,0, 1, "R8 read while data reported");
    step(8'h0B, 0,0,0, 0, 4'h2, 0, 0,0, 1, "R8 transmit kept");
    step(8'h09, 0,0,0, 0, 4'h2, 0, 0,0, 1, "R1 bit1 off hides transmit");
    step(8'h03, 0,0,0, 0, 4'h0, 0, 0,0, 1, "R1 held transmit reappears");
    step(8'h03, 0,0,0, 0, 4'h0, 0, 1,0, 1, "R8 read transmit");
    step(8'h03, 0,0,0, 0, 4'h0, 0, 0,0, 1, "R8 cleared by read");
    step(8'h02, 0,0,0, 1, 4'h0, 0, 0,0, 1, "R8 event");
    step(8'h02, 0,0,0, 1, 4'h0, 0, 0,1, 1, "R9 write with event");
    step(8'h02, 0,0,0, 0, 4'h0, 0, 0,0, 1, "R9 write wins");
    step(8'h02, 0,0,0, 1, 4'h0, 0, 0,0, 1, "R9 event again");
    step(8'h02, 0,0,0, 1, 4'h0, 1, 1,0, 1, "R9 read with event");
    step(8'h02, 0,0,0, 0, 4'h0, 1, 0,0, 1, "R9 event beats read");
    step(8'h02, 0,0,0, 0, 4'h0, 1, 0,1, 1, "R9 plain write");
    step(8'h02, 0,0,0, 0, 4'h0, 1, 0,0, 1, "R9 cleared by write");
    step(8'h02, 0,0,0, 1, 4'h0, 0, 0,0, 1, "R11 event before reset");
    step(8'h02, 0,0,0, 0, 4'h0, 0, 0,0, 0, "R11 in reset");
    step(8'h02, 0,0,0, 0, 4'h0, 0, 0,0, 1, "R11 reset cleared held");
    step(8'h00, 0,0,0, 0, 4'h0, 0, 0,0, 1, "R2 idle");
    repeat (3) @(negedge clk);
    done = 1'b1;
  end

  initial begin
    int cyc = 0;
    while (!done && cyc < 20000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      n_fail++;
      n_run++;
      $display("FAIL watchdog: got timeout, expected completion");
    end
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule